// File: doc/BRIEF.md
# Register-Window FIFO Port

This block is a memory-mapped slave whose data window is a queue, not a storage register. A bus write to the enqueue offset appends the write data to an internal first-in first-out buffer, which holds 4 entries of 64 bits by default. A bus read from the dequeue offset removes the oldest entry and returns it. Both accesses have side effects. An access that cannot complete is held off by deasserting its ready signal: a write to a full buffer stalls, and so does a read from an empty one. The access does not complete with stale or lost data.

The bus has separate read and write request channels. Each channel is a valid/ready pair with an offset and data, and read data is presented in the cycle the read handshake completes. Because the two channels are independent, an enqueue and a dequeue can complete in the same clock. A parameter selects one of two layouts. In the split layout the two directions use different offsets. In the shared layout one offset serves as the window for both. Two read-only offsets are also exposed: an 8-bit constant and the current element count.

Top module: `rwf_port`

## Requirements
- R1: After reset the buffer is empty: the count offset (0x18) reads 0, and a read of the dequeue offset holds `rd_ready` low.
- R2: Data written at the enqueue offset is returned by reads of the dequeue offset in the order it was written, one entry per completed read.
- R3: With `SPLIT_LAYOUT`=1, reads at 0x00 dequeue and writes at 0x08 enqueue. With `SPLIT_LAYOUT`=0, offset 0x00 enqueues on write and dequeues on read, and 0x08 is unmapped.
- R4: A write to the enqueue offset while 4 entries are held keeps `wr_ready` low until a dequeue frees a slot. The write then completes and its data is kept.
- R5: A read of the dequeue offset while the buffer is empty keeps `rd_ready` low until an entry is written. The read then completes and returns that entry.
- R6: A read of offset 0x10 returns 0x0D zero-extended to 64 bits. A write there is accepted at once and changes neither that value nor the buffer.
- R7: In the split layout, a read of the enqueue offset 0x08 returns zero without removing an entry. A write to the dequeue offset 0x00 is accepted and ignored.
- R8: Offset 0x18 reads the element count in its low bits. An enqueue and a dequeue that complete in the same cycle leave the count unchanged.
- R9: Any other offset reads zero and accepts writes without stalling, and neither kind of access has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request completes this cycle |
| rd_addr | input | ADDR_W (8) | Byte offset of the read |
| rd_data | output | DATA_W (64) | Read data, valid while rd_valid and rd_ready |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request completes this cycle |
| wr_addr | input | ADDR_W (8) | Byte offset of the write |
| wr_data | input | DATA_W (64) | Write data |

## Verification
Two situations are hard to reach from the ports. The first is a stalled request that is released by the opposite channel. The second is an enqueue and a dequeue completing in the same clock. The bench starts a dequeue on an empty buffer and an enqueue on a full one, checks that ready stays low for several cycles, and then issues the releasing access from a parallel thread. To produce the same-cycle case it starts both accesses at the same edge with two entries held. Random traffic then mixes window, constant, count and unmapped accesses against a model queue.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
   // Function selected by a bus offset
   typedef enum logic [1:0] {
      FN_NONE  = 2'd0,
      FN_DATA  = 2'd1,
      FN_CONST = 2'd2,
      FN_COUNT = 2'd3
   } rwf_fn_e;

   localparam int unsigned OFS_WINDOW_A = 'h00;   // dequeue (split) / both (shared)
   localparam int unsigned OFS_WINDOW_B = 'h08;   // enqueue (split)
   localparam int unsigned OFS_CONST    = 'h10;
   localparam int unsigned OFS_COUNT    = 'h18;
endpackage

// File: rtl/rwf_decode.sv
module rwf_decode
   import rwf_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter bit          SPLIT_LAYOUT = 1'b1
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] wr_addr,
   output rwf_fn_e           rd_fn,
   output logic              wr_is_push
);
   localparam logic [ADDR_W-1:0] A_WIN_A = ADDR_W'(OFS_WINDOW_A);
   localparam logic [ADDR_W-1:0] A_WIN_B = ADDR_W'(OFS_WINDOW_B);
   localparam logic [ADDR_W-1:0] A_CONST = ADDR_W'(OFS_CONST);
   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

   logic rd_is_pop;

   generate
      if (SPLIT_LAYOUT) begin : g_split
         assign rd_is_pop  = (rd_addr == A_WIN_A);
         assign wr_is_push = (wr_addr == A_WIN_B);
      end else begin : g_shared
         assign rd_is_pop  = (rd_addr == A_WIN_A);
         assign wr_is_push = (wr_addr == A_WIN_A);
      end
   endgenerate

   always_comb begin
      if (rd_is_pop)               rd_fn = FN_DATA;
      else if (rd_addr == A_CONST) rd_fn = FN_CONST;
      else if (rd_addr == A_COUNT) rd_fn = FN_COUNT;
      else                         rd_fn = FN_NONE;
   end
endmodule

// File: rtl/rwf_fifo.sv
module rwf_fifo #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rwf_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [PTR_W-1:0]  wptr, rptr;
   logic [DATA_W-1:0] slot_q [DEPTH];

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 slot_q[gi] <= '0;
            else if (push && wptr == PTR_W'(gi))        slot_q[gi] <= push_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head  = slot_q[rptr];
   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(DEPTH)));
   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
   // R8
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(count));
   // R2
   count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/rwf_rdmux.sv
module rwf_rdmux
   import rwf_pkg::*;
#(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned CONST_W = 8,
   parameter logic [CONST_W-1:0] CONST_VAL = 8'h0D
) (
   input  rwf_fn_e           fn,
   input  logic [DATA_W-1:0] head,
   input  logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] data
);
   generate
      if (CONST_W > DATA_W || CNT_W > DATA_W) begin : g_bad_width
         $error("rwf_rdmux: fields wider than the data path");
      end
   endgenerate

   always_comb begin
      unique case (fn)
         FN_DATA:  data = head;
         FN_CONST: data = DATA_W'(CONST_VAL);
         FN_COUNT: data = DATA_W'(count);
         default:  data = '0;
      endcase
   end
endmodule

// File: rtl/rwf_port.sv
module rwf_port
   import rwf_pkg::*;
#(
   parameter int unsigned DATA_W       = 64,
   parameter int unsigned DEPTH        = 4,
   parameter int unsigned ADDR_W       = 8,
   parameter bit          SPLIT_LAYOUT = 1'b1,
   parameter int unsigned CONST_W      = 8,
   parameter logic [CONST_W-1:0] CONST_VAL = 8'h0D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("rwf_port: ADDR_W too small for the offset map");
      end
   endgenerate

   rwf_fn_e          rd_fn;
   logic             wr_is_push;
   logic             push, pop, full, empty;
   logic [DATA_W-1:0] head;
   logic [CNT_W-1:0]  count;

   rwf_decode #(.ADDR_W(ADDR_W), .SPLIT_LAYOUT(SPLIT_LAYOUT)) u_dec (
      .rd_addr    (rd_addr),
      .wr_addr    (wr_addr),
      .rd_fn      (rd_fn),
      .wr_is_push (wr_is_push)
   );

   assign rd_ready = (rd_fn == FN_DATA) ? !empty : 1'b1;
   assign wr_ready = wr_is_push ? !full : 1'b1;
   assign pop      = rd_valid && (rd_fn == FN_DATA) && !empty;
   assign push     = wr_valid && wr_is_push && !full;

   rwf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (wr_data),
      .pop       (pop),
      .head      (head),
      .count     (count),
      .full      (full),
      .empty     (empty)
   );

   rwf_rdmux #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CONST_W(CONST_W),
               .CONST_VAL(CONST_VAL)) u_mux (
      .fn    (rd_fn),
      .head  (head),
      .count (count),
      .data  (rd_data)
   );

   // R6
   const_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_addr == ADDR_W'(OFS_CONST)) |-> (rd_ready && rd_data == DATA_W'(CONST_VAL)));
   // R5
   empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_addr == ADDR_W'(OFS_WINDOW_A) && count == '0) |-> !rd_ready);
   // R9
   unmapped_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr == ADDR_W'('h20)) |-> (wr_ready && !push));
endmodule

// File: tb/rwf_port_test.sv
module rwf_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_valid = 1'b0, wr_valid = 1'b0;
   logic [7:0]  rd_addr = '0, wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic        rd_ready, wr_ready;
   logic [63:0] rd_data;

   logic        s_rd_valid = 1'b0, s_wr_valid = 1'b0;
   logic [7:0]  s_rd_addr = '0, s_wr_addr = '0;
   logic [63:0] s_wr_data = '0;
   logic        s_rd_ready, s_wr_ready;
   logic [63:0] s_rd_data;

   int tests = 0, fails = 0;
   logic [63:0] model_q [$];

   always #5 clk = ~clk;

   rwf_port uut (
      .clk(clk), .rst_n(rst_n),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

   rwf_port #(.SPLIT_LAYOUT(1'b0)) uut_shared (
      .clk(clk), .rst_n(rst_n),
      .rd_valid(s_rd_valid), .rd_ready(s_rd_ready), .rd_addr(s_rd_addr), .rd_data(s_rd_data),
      .wr_valid(s_wr_valid), .wr_ready(s_wr_ready), .wr_addr(s_wr_addr), .wr_data(s_wr_data));

   function automatic logic [63:0] exp_read(input logic [7:0] a, input int n);
      case (a)
         8'h10:   return 64'h0D;
         8'h18:   return 64'(n);
         default: return 64'h0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = a;
      #1;
      while (!rd_ready) begin @(negedge clk); #1; end
      d = rd_data;
      @(posedge clk); #1;
      rd_valid = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] v);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = v;
      #1;
      while (!wr_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      wr_valid = 1'b0;
   endtask

   task automatic s_rd(input logic [7:0] a, output logic [63:0] d);
      @(negedge clk);
      s_rd_valid = 1'b1; s_rd_addr = a;
      #1;
      while (!s_rd_ready) begin @(negedge clk); #1; end
      d = s_rd_data;
      @(posedge clk); #1;
      s_rd_valid = 1'b0;
   endtask

   task automatic s_wr(input logic [7:0] a, input logic [63:0] v);
      @(negedge clk);
      s_wr_valid = 1'b1; s_wr_addr = a; s_wr_data = v;
      #1;
      while (!s_wr_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      s_wr_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [63:0] d;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd(8'h18, d); chk("R1 count after reset", d, 64'd0);
      @(negedge clk); rd_valid = 1'b1; rd_addr = 8'h00; #1;
      chk("R1 pop stalls after reset", 64'(rd_ready), 64'd0);
      @(posedge clk); #1 rd_valid = 1'b0;

      // R2 / R3: order through split offsets
      wr(8'h08, 64'h1111_0000_0000_0001);
      wr(8'h08, 64'h2222_0000_0000_0002);
      rd(8'h00, d); chk("R2 R3 first pop", d, 64'h1111_0000_0000_0001);
      rd(8'h00, d); chk("R2 R3 second pop", d, 64'h2222_0000_0000_0002);

      // R6: constant and ignored write
      wr(8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(8'h10, d); chk("R6 constant", d, 64'h0D);
      rd(8'h18, d); chk("R6 write to constant leaves count", d, 64'd0);

      // R7: write-only reads zero without pop; write to pop offset ignored
      wr(8'h08, 64'hABCD);
      rd(8'h08, d); chk("R7 push offset reads zero", d, 64'd0);
      wr(8'h00, 64'h9999);
      rd(8'h18, d); chk("R7 count unchanged", d, 64'd1);
      rd(8'h00, d); chk("R7 entry kept", d, 64'hABCD);

      // R9: unmapped offsets
      wr(8'h20, 64'h5555);
      rd(8'h20, d); chk("R9 unmapped reads zero", d, 64'd0);
      rd(8'h18, d); chk("R9 count unchanged", d, 64'd0);

      // R5: pop on empty released by push
      fork
         begin rd(8'h00, d); end
         begin
            repeat (3) @(negedge clk); #2;
            chk("R5 pop held while empty", 64'(rd_ready), 64'd0);
            wr(8'h08, 64'hFEED_0005);
         end
      join
      chk("R5 released pop data", d, 64'hFEED_0005);

      // R4: push on full released by pop
      for (int i = 0; i < 4; i++) wr(8'h08, 64'(100 + i));
      rd(8'h18, d); chk("R4 count full", d, 64'd4);
      fork
         begin wr(8'h08, 64'd200); end
         begin
            repeat (3) @(negedge clk); #2;
            chk("R4 push held while full", 64'(wr_ready), 64'd0);
            rd(8'h00, d);
            chk("R4 pop while full", d, 64'd100);
         end
      join
      rd(8'h18, d); chk("R4 count after release", d, 64'd4);
      for (int i = 1; i < 4; i++) begin
         rd(8'h00, d); chk("R4 R2 drain order", d, 64'(100 + i));
      end
      rd(8'h00, d); chk("R4 stalled data kept", d, 64'd200);

      // R8: simultaneous push and pop
      wr(8'h08, 64'd7); wr(8'h08, 64'd8);
      fork
         begin wr(8'h08, 64'd9); end
         begin rd(8'h00, d); end
      join
      chk("R8 pop during concurrent push", d, 64'd7);
      rd(8'h18, d); chk("R8 count held", d, 64'd2);
      rd(8'h00, d); chk("R8 next", d, 64'd8);
      rd(8'h00, d); chk("R8 last", d, 64'd9);

      // R3: shared layout
      s_wr(8'h00, 64'hA1); s_wr(8'h00, 64'hA2);
      s_rd(8'h08, d); chk("R3 shared 0x08 unmapped", d, 64'd0);
      s_rd(8'h00, d); chk("R3 shared pop 1", d, 64'hA1);
      s_rd(8'h00, d); chk("R3 shared pop 2", d, 64'hA2);
      s_rd(8'h18, d); chk("R3 shared count", d, 64'd0);

      // Random traffic against the model queue (R2 R6 R8 R9)
      for (int n = 0; n < 300; n++) begin
         int op;
         logic [63:0] v;
         op = int'($urandom % 6);
         v  = {$urandom, $urandom};
         if (op == 0 && model_q.size() < 4) begin
            wr(8'h08, v); model_q.push_back(v);
         end else if (op == 1 && model_q.size() > 0) begin
            rd(8'h00, d); chk("R2 random pop", d, model_q.pop_front());
         end else if (op == 2) begin
            rd(8'h10, d); chk("R6 random constant", d, exp_read(8'h10, model_q.size()));
         end else if (op == 3) begin
            rd(8'h18, d); chk("R8 random count", d, exp_read(8'h18, model_q.size()));
         end else if (op == 4) begin
            rd(8'h28, d); chk("R9 random unmapped", d, exp_read(8'h28, model_q.size()));
         end else begin
            wr(8'h30, v);
         end
      end
      while (model_q.size() > 0) begin
         rd(8'h00, d); chk("R2 final drain", d, model_q.pop_front());
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule